// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

A byte-wide serial port that runs either as the clock-driving master or as a clocked slave. Three configuration inputs select its behaviour: an enable, an idle clock level, and a 4-bit mode code. The mode code picks master operation with one of five clock sources, or slave operation with the select input either honoured or ignored. One receive buffer sits behind an internal shift register. Software writes the buffer to load the next outgoing byte and reads it to take the last received byte.

As master, a write starts a transfer. The port drives SCK for eight cycles, shifts the outgoing byte out MSB first and captures the incoming byte. As slave, the port follows an external SCK, and the byte written beforehand is shifted out. Two sticky status flags report misuse. One marks a write that arrives while a byte is shifting. The other marks a slave byte that completes while the buffer is still unread; that new byte is dropped. Software clears each flag with a pulse.

Top module: `spi_port`

## Requirements
- R1: With `en_i` low, `sck_oe_o`, `sdo_oe_o` and `busy_o` are low, and a buffer write is dropped: no transfer runs when the port is enabled later.
- R2: Master mode codes select the SCK period: 0000 gives 4, 1010 gives 8, 0001 gives 16 and 0010 gives 64 system clocks. A byte keeps `busy_o` high for 8 SCK periods, counted from the cycle after the write.
- R3: Mode 0011 is master clocked by `tmr_tick_i`. Each tick is one SCK half period, so 16 ticks complete a byte, and the transfer stalls while no ticks arrive.
- R4: `sck_o` rests at the `cpol_i` level whenever no byte is shifting. In master mode `sck_oe_o` is high.
- R5: Data is MSB first. The incoming bit is sampled on the first SCK edge away from idle, and the outgoing bit changes on the return edge. On completion, the received byte appears on `rdata_o` and `full_o` rises.
- R6: A buffer write while `busy_o` is high sets `wcol_o` and does not disturb the byte in flight. `wcol_o` holds until a `clr_wcol_i` pulse.
- R7: In slave mode, a byte that completes while `full_o` is high sets `ovf_o` and is discarded, and `rdata_o` keeps the older byte. `ovf_o` holds until a `clr_ovf_i` pulse.
- R8: A master transfer never sets `ovf_o`, even when the buffer was not read; the new byte replaces the old.
- R9: A `rd_i` pulse while no byte is shifting clears `full_o`.
- R10: Mode 0100 is a slave that honours the active-low `ss_ni`: while `ss_ni` is high, SCK edges are ignored and `sdo_oe_o` is low. Mode 0101 is a slave that ignores `ss_ni`.
- R11: Mode codes other than 0000, 0001, 0010, 0011, 0100, 0101 and 1010 are reserved. With such a code the port stays idle: writes start nothing, and both output enables stay low.
- R12: `busy_o` is high from the cycle after a master write until the byte completes. In slave mode it is high from the first leading SCK edge until the eighth trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| cpol_i | input | 1 | Idle SCK level |
| mode_i | input | 4 | Mode code |
| wr_i | input | 1 | Buffer write strobe |
| wdata_i | input | DATA_W | Byte to transmit |
| rd_i | input | 1 | Buffer read strobe |
| rdata_o | output | DATA_W | Last received byte |
| clr_wcol_i | input | 1 | Clear write-collision flag |
| clr_ovf_i | input | 1 | Clear overflow flag |
| tmr_tick_i | input | 1 | External timer tick for mode 0011 |
| sck_i | input | 1 | Serial clock in (slave) |
| sdi_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Slave select, active low |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Drive enable for SCK |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for SDO |
| busy_o | output | 1 | Byte shifting |
| full_o | output | 1 | Unread byte in buffer |
| wcol_o | output | 1 | Write collision flag |
| ovf_o | output | 1 | Receive overflow flag |

## Verification
The bench measures the exact busy length for each divider code and for the timer source. An off-by-one divider or a clock that counts full rather than half periods would show up as a wrong cycle count. Acting as slave, the bench records the master's output on leading edges and drives its own byte on trailing edges. Swapped edges or LSB-first order would therefore garble both bytes. It writes during a transfer to catch a collision that corrupts the byte in flight. It also completes two bytes without a read in both roles. A design that overwrites in slave mode would change `rdata_o`, and one that flags overflow in master mode would raise `ovf_o`. Finally, it toggles SCK with select high to expose a slave that does not gate on select.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    ROLE_IDLE   = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  typedef enum logic [2:0] {
    SRC_DIV_A = 3'd0,
    SRC_DIV_B = 3'd1,
    SRC_DIV_C = 3'd2,
    SRC_DIV_D = 3'd3,
    SRC_TMR   = 3'd4
  } sck_src_e;

  typedef struct packed {
    role_e    role;
    sck_src_e src;
    logic     ss_used;
  } mode_t;

  function automatic mode_t decode_mode(input logic [3:0] code);
    mode_t d;
    d.role    = ROLE_IDLE;
    d.src     = SRC_DIV_A;
    d.ss_used = 1'b0;
    case (code)
      4'b0000: begin d.role = ROLE_MASTER; d.src = SRC_DIV_A; end
      4'b1010: begin d.role = ROLE_MASTER; d.src = SRC_DIV_B; end
      4'b0001: begin d.role = ROLE_MASTER; d.src = SRC_DIV_C; end
      4'b0010: begin d.role = ROLE_MASTER; d.src = SRC_DIV_D; end
      4'b0011: begin d.role = ROLE_MASTER; d.src = SRC_TMR;   end
      4'b0100: begin d.role = ROLE_SLAVE;  d.ss_used = 1'b1;  end
      4'b0101: begin d.role = ROLE_SLAVE;  d.ss_used = 1'b0;  end
      default: d.role = ROLE_IDLE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 8,
  parameter int DIV_C = 16,
  parameter int DIV_D = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  sck_src_e src_i,
  input  logic     tmr_tick_i,
  output logic     half_tick_o
);

  localparam int HALF_MAX = DIV_D / 2;
  localparam int CW       = $clog2(HALF_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_lim;
  logic          wrap;
  logic          use_tmr;

  always_comb begin
    case (src_i)
      SRC_DIV_A: half_lim = CW'(DIV_A / 2 - 1);
      SRC_DIV_B: half_lim = CW'(DIV_B / 2 - 1);
      SRC_DIV_C: half_lim = CW'(DIV_C / 2 - 1);
      SRC_DIV_D: half_lim = CW'(DIV_D / 2 - 1);
      default:   half_lim = '0;
    endcase
  end

  assign use_tmr = (src_i == SRC_TMR);
  assign wrap    = (cnt_q == half_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || use_tmr || wrap) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign half_tick_o = run_i & (use_tmr ? tmr_tick_i : wrap);

endmodule

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         master_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         sdi_i,
  output logic         busy_o,
  output logic         phase_o,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic         sdo_o
);

  localparam int            CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          smp_q, phase_q, run_q;
  logic          do_lead, do_trail, last_bit;

  assign do_lead  = lead_i  & ~phase_q & ~clear_i;
  assign do_trail = trail_i &  phase_q & ~clear_i;
  assign last_bit = (cnt_q == LAST);
  assign done_o   = do_trail & last_bit;
  assign rx_o     = {sh_q[W-2:0], smp_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      smp_q   <= 1'b0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (load_i) begin
        sh_q  <= load_data_i;
        run_q <= master_i;
      end
      if (do_lead) begin
        smp_q   <= sdi_i;
        phase_q <= 1'b1;
      end
      if (do_trail) begin
        sh_q    <= rx_o;
        phase_q <= 1'b0;
        cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
        if (last_bit) run_q <= 1'b0;
      end
      if (clear_i) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
        run_q   <= 1'b0;
      end
    end
  end

  assign busy_o  = run_q | phase_q | (cnt_q != '0);
  assign phase_o = phase_q;
  assign sdo_o   = sh_q[W-1];

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 16,
  parameter int DIV_D       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic [3:0]        mode_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              clr_wcol_i,
  input  logic              clr_ovf_i,
  input  logic              tmr_tick_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              ss_ni,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              full_o,
  output logic              wcol_o,
  output logic              ovf_o
);

  mode_t dec;
  logic  is_master, is_slave, active;
  logic  sck_s, sdi_s, ss_s, sck_q;
  logic  selected, s_lead, s_trail, half_tick;
  logic  sh_lead, sh_trail, sh_sdi, sh_clear;
  logic  sh_busy, sh_phase, sh_done, sh_sdo;
  logic  [DATA_W-1:0] sh_rx;
  logic  busy_int, accept, collide, load;
  logic  ovf_set;
  logic  [DATA_W-1:0] buf_q;
  logic  full_q, wcol_q, ovf_q;

  assign dec       = decode_mode(mode_i);
  assign is_master = en_i & (dec.role == ROLE_MASTER);
  assign is_slave  = en_i & (dec.role == ROLE_SLAVE);
  assign active    = is_master | is_slave;

  // slave-side pins cross into clk_i
  spi_port_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, sdi_i, sck_i}),
    .q_o    ({ss_s, sdi_s, sck_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign selected = ~dec.ss_used | ~ss_s;
  assign s_lead   = is_slave & selected & (sck_s != cpol_i) & (sck_q == cpol_i);
  assign s_trail  = is_slave & selected & (sck_s == cpol_i) & (sck_q != cpol_i);

  spi_port_clkgen #(
    .DIV_A (DIV_A),
    .DIV_B (DIV_B),
    .DIV_C (DIV_C),
    .DIV_D (DIV_D)
  ) u_clkgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (is_master & sh_busy),
    .src_i       (dec.src),
    .tmr_tick_i  (tmr_tick_i),
    .half_tick_o (half_tick)
  );

  assign sh_lead  = is_master ? half_tick : s_lead;
  assign sh_trail = is_master ? half_tick : s_trail;
  assign sh_sdi   = is_master ? sdi_i : sdi_s;
  // deselect aborts a partial slave byte
  assign sh_clear = ~active | (is_slave & ~selected);

  assign busy_int = active & sh_busy;
  assign accept   = active & wr_i;
  assign collide  = accept & busy_int;
  assign load     = accept & ~busy_int;

  spi_port_shifter #(
    .W (DATA_W)
  ) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (sh_clear),
    .master_i    (is_master),
    .load_i      (load),
    .load_data_i (wdata_i),
    .lead_i      (sh_lead),
    .trail_i     (sh_trail),
    .sdi_i       (sh_sdi),
    .busy_o      (sh_busy),
    .phase_o     (sh_phase),
    .done_o      (sh_done),
    .rx_o        (sh_rx),
    .sdo_o       (sh_sdo)
  );

  // a read in the completion cycle counts as taken first
  assign ovf_set = sh_done & is_slave & full_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      wcol_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (sh_done) begin
        if (!ovf_set) begin
          buf_q  <= sh_rx;
          full_q <= 1'b1;
        end
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      if (collide)         wcol_q <= 1'b1;
      else if (clr_wcol_i) wcol_q <= 1'b0;
      if (ovf_set)         ovf_q  <= 1'b1;
      else if (clr_ovf_i)  ovf_q  <= 1'b0;
    end
  end

  assign sck_o    = cpol_i ^ (is_master & sh_phase);
  assign sck_oe_o = is_master;
  assign sdo_o    = sh_sdo;
  assign sdo_oe_o = is_master | (is_slave & selected);
  assign busy_o   = busy_int;
  assign full_o   = full_q;
  assign wcol_o   = wcol_q;
  assign ovf_o    = ovf_q;
  assign rdata_o  = buf_q;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              cpol_i,
  input logic [3:0]        mode_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              clr_wcol_i,
  input logic              clr_ovf_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sck_o,
  input logic              sck_oe_o,
  input logic              sdo_oe_o,
  input logic              busy_o,
  input logic              full_o,
  input logic              wcol_o,
  input logic              ovf_o
);

  mode_t dm;
  assign dm = decode_mode(mode_i);

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!sck_oe_o && !sdo_oe_o && !busy_o));

  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cpol_i));

  p_wcol_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_o) |=> wcol_o);

  p_wcol_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !clr_wcol_i) |=> wcol_o);

  p_ovf_keeps_buf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $stable(rdata_o));

  p_ovf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dm.role == ROLE_MASTER && !ovf_o) |=> !ovf_o);

  p_read_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_o) |=> !full_o);

  p_reserved_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dm.role == ROLE_IDLE) |-> (!busy_o && !sck_oe_o && !sdo_oe_o));

endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_spi_port.sv
module tb_spi_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, cpol = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic       wr = 1'b0, rd = 1'b0, clr_wcol = 1'b0, clr_ovf = 1'b0, tick = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       sck_in = 1'b0, sdi = 1'b0, ss_n = 1'b1;
  logic [7:0] rdata;
  logic       sck_out, sck_oe, sdo, sdo_oe, busy, full, wcol, ovf;

  int n_chk = 0, n_err = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  spi_port dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .mode_i(mode),
    .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata),
    .clr_wcol_i(clr_wcol), .clr_ovf_i(clr_ovf), .tmr_tick_i(tick),
    .sck_i(sck_in), .sdi_i(sdi), .ss_ni(ss_n),
    .sck_o(sck_out), .sck_oe_o(sck_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .busy_o(busy), .full_o(full), .wcol_o(wcol), .ovf_o(ovf)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_buf(input logic [7:0] d);
    wdata = d; wr = 1'b1; cyc(1); wr = 1'b0;
  endtask

  task automatic read_buf();
    rd = 1'b1; cyc(1); rd = 1'b0;
  endtask

  task automatic config_port(input logic e, input logic cp, input logic [3:0] m);
    en = e; cpol = cp; mode = m; sck_in = cp; cyc(4);
  endtask

  task automatic t_reset();
    check("R1", "busy after reset", busy, 0);
    check("R1", "oe after reset", {sck_oe, sdo_oe}, 0);
    check("R9", "full after reset", full, 0);
    check("R6", "wcol after reset", wcol, 0);
    check("R7", "ovf after reset", ovf, 0);
  endtask

  task automatic t_disabled();
    config_port(1'b0, 1'b0, 4'b0000);
    write_buf(8'hA5);
    cyc(5);
    check("R1", "busy when disabled", busy, 0);
    check("R1", "oe when disabled", {sck_oe, sdo_oe}, 0);
    en = 1'b1; cyc(3);
    check("R1", "dropped write starts nothing", busy, 0);
    check("R1", "dropped write fills nothing", full, 0);
    en = 1'b0; cyc(1);
  endtask

  task automatic t_reserved();
    logic [3:0] codes [3] = '{4'b0110, 4'b1011, 4'b1111};
    foreach (codes[i]) begin
      config_port(1'b1, 1'b0, codes[i]);
      write_buf(8'h3C);
      cyc(3);
      check("R11", $sformatf("busy mode %b", codes[i]), busy, 0);
      check("R11", $sformatf("oe mode %b", codes[i]), {sck_oe, sdo_oe}, 0);
    end
  endtask

  // bench acts as slave: captures sdo on leading edges, drives miso on trailing edges
  task automatic master_xfer(input logic [3:0] m, input logic cp, input logic [7:0] tx,
                             input logic [7:0] miso, input int exp_cyc, input int collide_at,
                             input bit do_read, input string tag);
    int n = 0;
    int idx = 6;
    logic prev;
    logic [7:0] mosi = 8'h00;
    config_port(1'b1, cp, m);
    check("R4", {tag, " idle sck"}, sck_out, cp);
    check("R4", {tag, " sck_oe"}, sck_oe, 1);
    sdi = miso[7];
    prev = sck_out;
    write_buf(tx);
    while (busy && n < 5000) begin
      n++;
      if (sck_out !== prev) begin
        if (sck_out !== cp) mosi = {mosi[6:0], sdo};
        else if (idx >= 0) begin sdi = miso[idx]; idx--; end
        prev = sck_out;
      end
      if (n == collide_at) begin wr = 1'b1; wdata = ~tx; end
      else wr = 1'b0;
      cyc(1);
    end
    wr = 1'b0;
    check("R2", {tag, " busy cycles (R12)"}, n, exp_cyc);
    check("R5", {tag, " bits sent msb first"}, mosi, tx);
    check("R5", {tag, " byte received"}, rdata, miso);
    check("R5", {tag, " full set"}, full, 1);
    check("R4", {tag, " sck back at idle"}, sck_out, cp);
    if (do_read) begin
      read_buf();
      check("R9", {tag, " read empties"}, full, 0);
    end
  endtask

  task automatic t_master_divs();
    master_xfer(4'b0000, 1'b0, 8'hA5, 8'h3C, 32,  -1, 1'b1, "div4");
    master_xfer(4'b0001, 1'b1, 8'h81, 8'h7E, 128, -1, 1'b1, "div16");
    master_xfer(4'b0010, 1'b0, 8'h96, 8'h0F, 512, -1, 1'b1, "div64");
    master_xfer(4'b1010, 1'b1, 8'h5A, 8'hC3, 64,  -1, 1'b1, "div8");
  endtask

  task automatic t_timer();
    config_port(1'b1, 1'b0, 4'b0011);
    sdi = 1'b1;
    write_buf(8'h00);
    for (int k = 0; k < 15; k++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(2);
    end
    check("R3", "busy after 15 ticks", busy, 1);
    cyc(20);
    check("R3", "stalled without ticks", busy, 1);
    tick = 1'b1; cyc(1); tick = 1'b0;
    check("R3", "done on 16th tick", busy, 0);
    check("R3", "timer byte received", rdata, 8'hFF);
    read_buf();
  endtask

  task automatic t_wcol();
    master_xfer(4'b0010, 1'b0, 8'hC3, 8'h24, 512, 40, 1'b1, "collide");
    check("R6", "wcol set", wcol, 1);
    cyc(5);
    check("R6", "wcol sticky", wcol, 1);
    clr_wcol = 1'b1; cyc(1); clr_wcol = 1'b0;
    check("R6", "wcol cleared", wcol, 0);
  endtask

  task automatic t_master_no_ovf();
    master_xfer(4'b0000, 1'b0, 8'h11, 8'h5E, 32, -1, 1'b0, "m_first");
    master_xfer(4'b0000, 1'b0, 8'h22, 8'hB7, 32, -1, 1'b0, "m_second");
    check("R8", "no master overflow", ovf, 0);
    check("R8", "master replaces byte", rdata, 8'hB7);
    read_buf();
  endtask

  // bench acts as master on sck_i/sdi_i
  task automatic slave_xfer(input logic cp, input logic [7:0] mosi, output logic [7:0] miso);
    for (int i = 7; i >= 0; i--) begin
      sdi = mosi[i];
      cyc(4);
      miso[i] = sdo;
      sck_in = ~cp;
      cyc(4);
      sck_in = cp;
    end
    cyc(4);
  endtask

  task automatic t_slave_ss();
    logic [7:0] got;
    ss_n = 1'b1;
    config_port(1'b1, 1'b0, 4'b0101);
    write_buf(8'h6D);
    check("R10", "ss ignored: sdo_oe", sdo_oe, 1);
    slave_xfer(1'b0, 8'h3A, got);
    check("R5", "slave shifted out msb first", got, 8'h6D);
    check("R10", "ss ignored: byte received", rdata, 8'h3A);
    check("R5", "slave full", full, 1);
    read_buf();
    config_port(1'b1, 1'b1, 4'b0100);
    check("R10", "deselected sdo_oe", sdo_oe, 0);
    slave_xfer(1'b1, 8'hFF, got);
    check("R10", "deselected edges ignored", full, 0);
    check("R12", "deselected not busy", busy, 0);
    ss_n = 1'b0; cyc(4);
    check("R10", "selected sdo_oe", sdo_oe, 1);
    write_buf(8'h42);
    slave_xfer(1'b1, 8'h99, got);
    check("R5", "slave cpol1 sent", got, 8'h42);
    check("R10", "selected byte received", rdata, 8'h99);
    read_buf();
    ss_n = 1'b1;
  endtask

  task automatic t_slave_ovf();
    logic [7:0] got;
    config_port(1'b1, 1'b0, 4'b0101);
    slave_xfer(1'b0, 8'h12, got);
    check("R7", "first byte", rdata, 8'h12);
    slave_xfer(1'b0, 8'h34, got);
    check("R7", "overflow set", ovf, 1);
    check("R7", "old byte kept", rdata, 8'h12);
    cyc(5);
    check("R7", "overflow sticky", ovf, 1);
    clr_ovf = 1'b1; cyc(1); clr_ovf = 1'b0;
    check("R7", "overflow cleared", ovf, 0);
    read_buf();
    check("R9", "slave read empties", full, 0);
    slave_xfer(1'b0, 8'h56, got);
    check("R7", "no overflow after read", ovf, 0);
    check("R7", "new byte after read", rdata, 8'h56);
    read_buf();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_disabled();
    t_reserved();
    t_master_divs();
    t_timer();
    t_wcol();
    t_master_no_ovf();
    t_slave_ss();
    t_slave_ovf();
    cyc(5);
    finish_run();
  end

endmodule